// File: doc/BRIEF.md
# Frame Buffer Fetch Address Generator

This block produces the memory read addresses that a display controller uses to fetch its frame buffer. Software programs a base address and a frame length in bytes. The block keeps its own fetch pointer, which walks through the buffer one fixed-size burst at a time. It moves only when a read request is accepted.

The base register acts as a shadow. A newly written base takes effect only when the display is switched on, or when the pointer wraps at the end of the buffer. The end address of the frame in progress is captured when the pointer is reloaded. A base write or a length change partway through a frame therefore moves neither the current frame nor its end. Software can read the pointer to estimate which line is being fetched. The pointer has no reset value and is defined only after the first enable edge.

Top module: `fb_addr_gen`

## Requirements
- R1: A write to the base register stores the written address with bits [3:0] forced to zero. The fetch pointer does not change because of the write.
- R2: When `disp_en` rises from 0 to 1, the fetch pointer is loaded from the base register at that clock edge and is visible on `cur_addr` in the following cycle.
- R3: `fetch_req` is high only while `disp_en` is high and the pointer has already been loaded. It is low in the cycle in which `disp_en` is first seen high, and whenever `disp_en` is low.
- R4: In a cycle where `fetch_req` and `fetch_ack` are both high, the pointer advances by 16 bytes (one burst). In any other cycle while enabled, it holds.
- R5: The last burst address of a frame is base + (frame length rounded down to a multiple of 16) − 16, with both values captured at the latest reload. An accepted transfer at that address reloads the pointer from the base register instead of advancing it.
- R6: `eof_pulse` is high for exactly one cycle: the cycle after the final transfer is accepted. In that cycle `cur_addr` already shows the reloaded base.
- R7: While `disp_en` is low, the pointer holds its value whatever `fetch_ack` does.
- R8: Changing the base register or `frame_len` during a frame does not change the end of that frame. The new values govern only the next frame.
- R9: After reset, `fetch_req` and `eof_pulse` are low and the base register reads as zero. The fetch pointer is not reset.
- R10: Bits [3:0] of `cur_addr` are always zero once the pointer has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_en | input | 1 | Display enable; its rising edge loads the pointer |
| base_wr | input | 1 | Write strobe for the base register |
| base_wdata | input | 32 | Base address to write |
| frame_len | input | LEN_W | Frame size in bytes, a multiple of 16, at least 16 |
| fetch_ack | input | 1 | Memory side accepts the current request |
| fetch_req | output | 1 | Read request for the burst at `cur_addr` |
| cur_addr | output | 32 | Current fetch pointer, also the status read value |
| eof_pulse | output | 1 | One-cycle end-of-frame marker |

## Verification
The assertions assume that `frame_len` holds at least one burst. They also assume that once the pointer is loaded, only accepted transfers, a wrap or a fresh enable edge move it. Comparisons against the pointer's previous value are gated by an internal flag that is set at the first load, so the undefined pointer before enable is never inspected. The stimulus programs lengths of 16-byte multiples, always enables once before it observes `cur_addr`, and drives `fetch_ack` only from its own tasks, both with `fetch_req` high and while the display is off.

// File: rtl/fb_dma_pkg.sv
// Package: shared address type and burst geometry for the frame fetch block.
// Assumes: byte addressing, burst size a power of two.
package fb_dma_pkg;
    parameter int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/fb_base_shadow.sv
// Module: fb_base_shadow
// Holds the software-programmed base address. The stored value is only a
// shadow: consumers sample it when they reload, never on the write itself.
// Assumes: BURST_BYTES is a power of two; low address bits are discarded.
module fb_base_shadow #(
    parameter int BURST_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  fb_dma_pkg::addr_t   wdata_i,
    output fb_dma_pkg::addr_t   base_o
);
    import fb_dma_pkg::*;
    localparam addr_t LOW_MASK = addr_t'(BURST_BYTES - 1);

    addr_t base_q;

    // Capture a write with the sub-burst bits cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_i)
            base_q <= wdata_i & ~LOW_MASK;
    end

    assign base_o = base_q;

    // R1
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[$clog2(BURST_BYTES)-1:0] == '0);
endmodule

// File: rtl/fb_end_latch.sv
// Module: fb_end_latch
// Computes the last burst address of a frame and freezes it at each reload,
// so later base or length changes only affect the next frame.
// Assumes: frame length is at least one burst; no reset needed because the
// value is meaningless until the first reload.
module fb_end_latch #(
    parameter int LEN_W       = 20,
    parameter int BURST_BYTES = 16
) (
    input  logic                clk,
    input  logic                reload_i,
    input  fb_dma_pkg::addr_t   base_i,
    input  logic [LEN_W-1:0]    len_i,
    output fb_dma_pkg::addr_t   end_o
);
    import fb_dma_pkg::*;
    localparam addr_t LOW_MASK = addr_t'(BURST_BYTES - 1);
    localparam addr_t BURST_A  = addr_t'(BURST_BYTES);

    addr_t len_bytes;
    addr_t end_q;

    // Round the length down to whole bursts.
    always_comb len_bytes = addr_t'(len_i) & ~LOW_MASK;

    // Freeze the last burst address on a reload.
    always_ff @(posedge clk) begin
        if (reload_i)
            end_q <= base_i + len_bytes - BURST_A;
    end

    assign end_o = end_q;
endmodule

// File: rtl/fb_cur_ptr.sv
// Module: fb_cur_ptr
// Fetch pointer: loads from base on the enable edge, steps one burst per
// accepted transfer, and wraps to base after the last burst of a frame.
// Assumes: xfer_i is only high while enabled; the pointer has no reset.
module fb_cur_ptr #(
    parameter int BURST_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                en_i,
    input  logic                xfer_i,
    input  fb_dma_pkg::addr_t   base_i,
    input  fb_dma_pkg::addr_t   end_i,
    output fb_dma_pkg::addr_t   cur_o,
    output logic                wrap_o,
    output logic                eof_o
);
    import fb_dma_pkg::*;
    localparam addr_t BURST_A = addr_t'(BURST_BYTES);
    localparam int    LOW_B   = $clog2(BURST_BYTES);

    addr_t cur_q;
    logic  eof_q;
    logic  loaded_q;
    logic  wrap;

    // Final burst of the frame is being accepted.
    always_comb wrap = xfer_i && (cur_q == end_i);

    // Pointer update: enable-edge load, wrap reload, or burst step.
    always_ff @(posedge clk) begin
        if (load_i || wrap)
            cur_q <= base_i;
        else if (xfer_i)
            cur_q <= cur_q + BURST_A;
    end

    // End-of-frame marker, one cycle after the final transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eof_q <= 1'b0;
        else
            eof_q <= wrap && !load_i;
    end

    // Tracks whether the pointer has ever been loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            loaded_q <= 1'b0;
        else if (load_i)
            loaded_q <= 1'b1;
    end

    assign cur_o  = cur_q;
    assign wrap_o = wrap;
    assign eof_o  = eof_q;

    // R2
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cur_q == $past(base_i));
    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && xfer_i && !load_i && cur_q != end_i) |=> cur_q == $past(cur_q) + BURST_A);
    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && xfer_i && !load_i && cur_q == end_i) |=> cur_q == $past(base_i));
    // R6
    eof_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && xfer_i && !load_i && cur_q == end_i) |=> eof_o);
    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && !en_i && !load_i) |=> cur_q == $past(cur_q));
    // R10
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |-> cur_q[LOW_B-1:0] == '0);
endmodule

// File: rtl/fb_addr_gen.sv
// Module: fb_addr_gen (top)
// Frame buffer fetch address generator. Detects the enable edge, raises
// the fetch request while enabled, and ties together the base shadow,
// end-address latch and fetch pointer.
// Assumes: frame_len is a multiple of 16 bytes and at least 16.
module fb_addr_gen #(
    parameter int LEN_W       = 20,
    parameter int BURST_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    input  logic              base_wr,
    input  logic [31:0]       base_wdata,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [31:0]       cur_addr,
    output logic              eof_pulse
);
    import fb_dma_pkg::*;

    logic  en_q;
    logic  en_rise;
    logic  xfer;
    logic  wrap;
    addr_t base_val;
    addr_t end_val;

    // Registered enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= disp_en;
    end

    always_comb begin
        en_rise   = disp_en && !en_q;
        fetch_req = disp_en && en_q;
        xfer      = fetch_req && fetch_ack;
    end

    fb_base_shadow #(.BURST_BYTES(BURST_BYTES)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (base_wr),
        .wdata_i (base_wdata),
        .base_o  (base_val)
    );

    fb_end_latch #(.LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_end (
        .clk      (clk),
        .reload_i (en_rise || wrap),
        .base_i   (base_val),
        .len_i    (frame_len),
        .end_o    (end_val)
    );

    fb_cur_ptr #(.BURST_BYTES(BURST_BYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (en_rise),
        .en_i   (disp_en),
        .xfer_i (xfer),
        .base_i (base_val),
        .end_i  (end_val),
        .cur_o  (cur_addr),
        .wrap_o (wrap),
        .eof_o  (eof_pulse)
    );

    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (disp_en && $past(disp_en)));
    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!fetch_req && !eof_pulse));
endmodule

// File: tb/fb_addr_gen_test.sv
module fb_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_en = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [19:0] frame_len = 20'd64;
    logic        fetch_ack = 1'b0;
    logic        fetch_req;
    logic [31:0] cur_addr;
    logic        eof_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fb_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .base_wr(base_wr),
        .base_wdata(base_wdata), .frame_len(frame_len), .fetch_ack(fetch_ack),
        .fetch_req(fetch_req), .cur_addr(cur_addr), .eof_pulse(eof_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock with ack driven; returns at the following negedge.
    task automatic tick(input logic a);
        fetch_ack = a;
        @(negedge clk);
    endtask

    task automatic write_base(input logic [31:0] v);
        base_wr = 1'b1; base_wdata = v;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 req after reset", {31'b0, fetch_req}, 32'd0);
        chk("R9 eof after reset", {31'b0, eof_pulse}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_enable;
        write_base(32'h1000_0007);
        disp_en = 1'b1;
        #1;
        chk("R3 no req in edge cycle", {31'b0, fetch_req}, 32'd0);
        @(negedge clk);
        chk("R2 load base on enable", cur_addr, 32'h1000_0000);
        chk("R1 low bits forced", {28'b0, cur_addr[3:0]}, 32'd0);
        chk("R3 req after load", {31'b0, fetch_req}, 32'd1);
    endtask

    task automatic t_advance;
        tick(1'b1);
        chk("R4 step one burst", cur_addr, 32'h1000_0010);
        tick(1'b0);
        tick(1'b0);
        chk("R4 hold without ack", cur_addr, 32'h1000_0010);
        tick(1'b1);
        chk("R4 second step", cur_addr, 32'h1000_0020);
        chk("R10 aligned pointer", {28'b0, cur_addr[3:0]}, 32'd0);
    endtask

    task automatic t_shadow_wrap;
        fetch_ack = 1'b0;
        write_base(32'h2000_0000);
        frame_len = 20'd32;
        chk("R1 base write leaves pointer", cur_addr, 32'h1000_0020);
        tick(1'b1);
        chk("R8 old end still used", cur_addr, 32'h1000_0030);
        chk("R6 no eof mid frame", {31'b0, eof_pulse}, 32'd0);
        tick(1'b1);
        chk("R5 wrap to new base", cur_addr, 32'h2000_0000);
        chk("R6 eof with reload", {31'b0, eof_pulse}, 32'd1);
        tick(1'b0);
        chk("R6 eof one cycle", {31'b0, eof_pulse}, 32'd0);
        tick(1'b1);
        chk("R8 new length step", cur_addr, 32'h2000_0010);
        tick(1'b1);
        chk("R5 wrap after new length", cur_addr, 32'h2000_0000);
        chk("R6 eof second frame", {31'b0, eof_pulse}, 32'd1);
        fetch_ack = 1'b0;
    endtask

    task automatic t_disable;
        tick(1'b1);
        chk("R4 pre-disable step", cur_addr, 32'h2000_0010);
        disp_en = 1'b0;
        fetch_ack = 1'b1;
        #1;
        chk("R3 no req while off", {31'b0, fetch_req}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 hold while off", cur_addr, 32'h2000_0010);
        chk("R3 still no req", {31'b0, fetch_req}, 32'd0);
        fetch_ack = 1'b0;
        write_base(32'h3000_004F);
        chk("R1 write while off", cur_addr, 32'h2000_0010);
        disp_en = 1'b1;
        @(negedge clk);
        chk("R2 reload on re-enable", cur_addr, 32'h3000_0040);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable();
        t_advance();
        t_shadow_wrap();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule